// File: doc/BRIEF.md
# Clear-On-Read Interrupt Aggregator

This block combines two kinds of event into one active-low interrupt request line. The first kind is a pulse from a serial-bus timeout detector. The second kind is a change on any of a set of general-purpose inputs. Each input first passes through a multi-flop synchronizer and is then compared against a snapshot of its own value. Every event sets a sticky flag in a status register. The timeout has one register. The inputs have one register for each group of eight.

Software services the interrupt through a single-cycle read strobe with an address. A read returns the addressed register's flags and clears them in the same cycle. The interrupt line stays low until every register that holds a pending flag has been read. Reading one register therefore never acknowledges the others. Input change flags can only be set for inputs whose enable bit is high.

Top module: `pirq_aggregator`

## Requirements
- R1: While and after reset, `irq_n` is 1, `rd_data` is 0 and all flags are clear.
- R2: A one-cycle `tmo_evt` pulse sets the timeout flag at the next clock edge, so `irq_n` is 0 in the cycle after the pulse. The flag is bit 0 of the register at address 0x48; bits 7:1 of that register read 0.
- R3: A change on an enabled input shows up as a flag after three clock edges, which are the two synchronizer stages plus the flag register. Inputs 7:0 map to bits 7:0 of address 0x5A, and inputs 15:8 map to bits 7:0 of address 0x5B.
- R4: An input whose enable bit is 0 never sets its flag, whatever it does.
- R5: A read strobe makes `rd_data` equal to the addressed register's flags at the next edge and clears those flags at that same edge. `irq_n` stays 0 while any other register still holds a flag.
- R6: An event that arrives in the same cycle as the read that clears its register stays pending after the read.
- R7: A read of any address other than 0x48, 0x5A or 0x5B returns 0 and clears no flag.
- R8: A change flag is sticky. It stays set when the input returns to its old value before the read. After a read, an input that holds steady at its new value does not flag again.
- R9: `irq_n` equals the NOR of all pending flags. It can only rise in the cycle after a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tmo_evt | input | 1 | One-cycle timeout event pulse, synchronous to clk |
| gpio_in | input | NUM_GPIO | Asynchronous general-purpose inputs |
| gpio_irq_en | input | NUM_GPIO | Per-input enable for change flags |
| rd_stb | input | 1 | Single-cycle read strobe |
| rd_addr | input | ADDR_W | Status register address |
| rd_data | output | 8 | Read data, valid the cycle after the strobe and held until the next strobe |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The assertions assume three things about the inputs. First, `tmo_evt` and `rd_stb` are synchronous to `clk`. Second, `gpio_irq_en` changes only between events. Third, `gpio_in` is low when reset is released, because the synchronizer and the snapshots reset to zero and a high input would flag at once.

The stimulus respects all three. It drives every input on the falling edge and holds the general-purpose inputs at zero through reset. It sweeps a single toggle across each of the sixteen inputs, applies enable masks, and places a timeout pulse in the same cycle as the read that clears it. Expected register values are built from bit positions in the bench.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
   localparam int STAT_W = 8;
   typedef logic [STAT_W-1:0] stat_byte_t;

   function automatic int unsigned bank_count(input int unsigned n_in);
      return n_in / STAT_W;
   endfunction
endpackage

// File: rtl/pirq_sync.sv
module pirq_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pirq_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pirq_tmo_flag.sv
module pirq_tmo_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic rd_hit,
   output logic flag
);
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= (flag_q & ~rd_hit) | evt;
   end

   assign flag = flag_q;

   // R6
   evt_during_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && evt) |=> flag_q);

   // R2
   evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> flag_q);
endmodule

// File: rtl/pirq_chg_bank.sv
module pirq_chg_bank
   import pirq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  stat_byte_t din,
   input  stat_byte_t en,
   input  logic       rd_hit,
   output stat_byte_t flags
);
   stat_byte_t prev_q, snap_q, flags_q;
   stat_byte_t ref_v, evt_v, flags_d;

   always_comb begin
      ref_v   = rd_hit ? prev_q : snap_q;
      evt_v   = en & (din ^ ref_v);
      flags_d = (rd_hit ? stat_byte_t'(0) : flags_q) | evt_v;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= '0;
         snap_q  <= '0;
         flags_q <= '0;
      end else begin
         prev_q  <= din;
         flags_q <= flags_d;
         if (rd_hit) snap_q <= din;
      end
   end

   assign flags = flags_q;

   // R4
   disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((flags_q & ~$past(flags_q) & ~$past(en)) == '0));

   // R5
   read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && (din == prev_q)) |=> (flags_q == '0));

   // R8
   steady_no_reflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && (din == prev_q)) ##1 (din == $past(din)) |=> (flags_q == '0));
endmodule

// File: rtl/pirq_aggregator.sv
module pirq_aggregator
   import pirq_pkg::*;
#(
   parameter int NUM_GPIO    = 16,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int TMO_ADDR    = 'h48,
   parameter int GPIO_BASE   = 'h5A
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tmo_evt,
   input  logic [NUM_GPIO-1:0] gpio_in,
   input  logic [NUM_GPIO-1:0] gpio_irq_en,
   input  logic                rd_stb,
   input  logic [ADDR_W-1:0]   rd_addr,
   output logic [STAT_W-1:0]   rd_data,
   output logic                irq_n
);
   localparam int NUM_BANKS = bank_count(NUM_GPIO);

   generate
      if ((NUM_GPIO % STAT_W) != 0 || NUM_GPIO < STAT_W) begin : g_bad_width
         $error("pirq_aggregator: NUM_GPIO must be a nonzero multiple of 8");
      end
      if (TMO_ADDR >= GPIO_BASE && TMO_ADDR < GPIO_BASE + NUM_BANKS) begin : g_bad_map
         $error("pirq_aggregator: timeout address overlaps input banks");
      end
      if (GPIO_BASE + NUM_BANKS > (1 << ADDR_W) || TMO_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("pirq_aggregator: register map exceeds address width");
      end
   endgenerate

   logic [NUM_GPIO-1:0]  gpio_s;
   logic                 tmo_hit;
   logic                 tmo_flag;
   logic [NUM_BANKS-1:0] bank_hit;
   logic [NUM_BANKS-1:0] bank_any;
   stat_byte_t           bank_flags [NUM_BANKS];
   stat_byte_t           rd_mux;
   stat_byte_t           rd_q;
   logic                 any_hit;

   pirq_sync #(.W(NUM_GPIO), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (gpio_in),
      .q     (gpio_s)
   );

   assign tmo_hit = rd_stb && (rd_addr == ADDR_W'(TMO_ADDR));

   pirq_tmo_flag u_tmo (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt    (tmo_evt),
      .rd_hit (tmo_hit),
      .flag   (tmo_flag)
   );

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         localparam logic [ADDR_W-1:0] BANK_ADDR = ADDR_W'(GPIO_BASE + b);

         assign bank_hit[b] = rd_stb && (rd_addr == BANK_ADDR);

         pirq_chg_bank u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .din    (gpio_s[b*STAT_W +: STAT_W]),
            .en     (gpio_irq_en[b*STAT_W +: STAT_W]),
            .rd_hit (bank_hit[b]),
            .flags  (bank_flags[b])
         );

         assign bank_any[b] = |bank_flags[b];
      end
   endgenerate

   assign any_hit = tmo_hit | (|bank_hit);

   always_comb begin
      rd_mux = '0;
      if (tmo_hit) rd_mux = {{(STAT_W-1){1'b0}}, tmo_flag};
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (bank_hit[b]) rd_mux = bank_flags[b];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rd_q <= '0;
      else if (rd_stb) rd_q <= rd_mux;
   end

   assign rd_data = rd_q;
   assign irq_n   = ~(tmo_flag | (|bank_any));

   // R9
   irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_n) |-> $past(rd_stb));

   // R2
   tmo_asserts_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_evt |=> !irq_n);

   // R7
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !any_hit) |=> (rd_data == '0));

   // R7
   unmapped_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !any_hit && !irq_n) |=> !irq_n);
endmodule

// File: tb/pirq_aggregator_bench.sv
module pirq_aggregator_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tmo_evt = 1'b0;
   logic [15:0] gpio_in = '0;
   logic [15:0] gpio_irq_en = '0;
   logic        rd_stb = 1'b0;
   logic [7:0]  rd_addr = '0;
   logic [7:0]  rd_data;
   logic        irq_n;

   int total = 0;
   int fails = 0;

   always #5 clk = ~clk;

   pirq_aggregator u_pirq_aggregator (
      .clk         (clk),
      .rst_n       (rst_n),
      .tmo_evt     (tmo_evt),
      .gpio_in     (gpio_in),
      .gpio_irq_en (gpio_irq_en),
      .rd_stb      (rd_stb),
      .rd_addr     (rd_addr),
      .rd_data     (rd_data),
      .irq_n       (irq_n)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_read(input logic [7:0] a, output logic [7:0] d);
      rd_addr = a;
      rd_stb  = 1'b1;
      @(negedge clk);
      rd_stb  = 1'b0;
      d = rd_data;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic tmo_pulse();
      tmo_evt = 1'b1;
      @(negedge clk);
      tmo_evt = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      logic [7:0] d;
      idle(3);
      chk("R1 irq_n in reset", {7'b0, irq_n}, 8'h01);
      rst_n = 1'b1;
      idle(2);
      chk("R1 irq_n after reset", {7'b0, irq_n}, 8'h01);
      chk("R1 rd_data after reset", rd_data, 8'h00);

      // R3 / R5 / R8: single toggle on every input in turn
      gpio_irq_en = 16'hFFFF;
      for (int i = 0; i < 16; i++) begin
         gpio_in[i] = ~gpio_in[i];
         idle(2);
         chk("R3 no flag before third edge", {7'b0, irq_n}, 8'h01);
         idle(1);
         chk("R3 flag after third edge", {7'b0, irq_n}, 8'h00);
         do_read((i < 8) ? 8'h5B : 8'h5A, d);
         chk("R3 other bank empty", d, 8'h00);
         chk("R5 other bank read keeps irq", {7'b0, irq_n}, 8'h00);
         do_read((i < 8) ? 8'h5A : 8'h5B, d);
         chk("R3 bit position", d, 8'h01 << (i % 8));
         chk("R5 read releases irq", {7'b0, irq_n}, 8'h01);
         idle(3);
         do_read((i < 8) ? 8'h5A : 8'h5B, d);
         chk("R8 steady input no reflag", d, 8'h00);
      end

      // R4: disabled inputs never flag
      gpio_irq_en = 16'h0000;
      gpio_in = 16'h0000;
      idle(6);
      chk("R4 irq_n with enables off", {7'b0, irq_n}, 8'h01);
      do_read(8'h5A, d);
      chk("R4 bank0 disabled", d, 8'h00);
      do_read(8'h5B, d);
      chk("R4 bank1 disabled", d, 8'h00);

      // R4: partial enable mask
      gpio_irq_en = 16'hA5C3;
      gpio_in = 16'hFFFF;
      idle(5);
      do_read(8'h5A, d);
      chk("R4 bank0 masked", d, 8'hC3);
      do_read(8'h5B, d);
      chk("R4 bank1 masked", d, 8'hA5);
      chk("R4 irq released", {7'b0, irq_n}, 8'h01);

      // R8: pulse that returns before the read stays flagged
      gpio_irq_en = 16'hFFFF;
      gpio_in[3] = 1'b0;
      idle(2);
      gpio_in[3] = 1'b1;
      idle(6);
      chk("R8 irq after returned pulse", {7'b0, irq_n}, 8'h00);
      do_read(8'h5A, d);
      chk("R8 sticky flag", d, 8'h08);

      // R2 / R7: timeout then unmapped read
      tmo_pulse();
      chk("R2 irq after timeout", {7'b0, irq_n}, 8'h00);
      do_read(8'h50, d);
      chk("R7 unmapped reads zero", d, 8'h00);
      chk("R7 unmapped keeps irq", {7'b0, irq_n}, 8'h00);
      do_read(8'h48, d);
      chk("R2 timeout register", d, 8'h01);
      chk("R2 irq released", {7'b0, irq_n}, 8'h01);

      // R5: two pending registers need two reads
      tmo_pulse();
      gpio_in[9] = 1'b0;
      idle(4);
      do_read(8'h48, d);
      chk("R5 timeout read", d, 8'h01);
      chk("R5 irq held by bank1", {7'b0, irq_n}, 8'h00);
      do_read(8'h5B, d);
      chk("R5 bank1 read", d, 8'h02);
      chk("R5 irq released after all", {7'b0, irq_n}, 8'h01);

      // R6: event in the same cycle as the clearing read
      tmo_pulse();
      rd_addr = 8'h48;
      rd_stb  = 1'b1;
      tmo_evt = 1'b1;
      @(negedge clk);
      rd_stb  = 1'b0;
      tmo_evt = 1'b0;
      chk("R6 read data", rd_data, 8'h01);
      chk("R6 irq kept", {7'b0, irq_n}, 8'h00);
      do_read(8'h48, d);
      chk("R6 event kept pending", d, 8'h01);
      chk("R6 irq released", {7'b0, irq_n}, 8'h01);

      // R9: irq holds with no read
      tmo_pulse();
      idle(20);
      chk("R9 irq holds without read", {7'b0, irq_n}, 8'h00);
      do_read(8'h48, d);
      chk("R9 irq rises after read", {7'b0, irq_n}, 8'h01);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule